// File: doc/BRIEF.md
# Two-wire serial EEPROM slave controller

This block is the bus-facing half of a small serial EEPROM that sits as a slave on a two-wire bus. A fast system clock oversamples the bus clock and data pins through a synchronizer. From those samples the block finds start and stop conditions and frames 9-clock transfer units: 8 data bits, most significant first, then one acknowledge bit. The first byte after a start carries a device-type code, chip-select bits and a direction bit. The block acknowledges a byte addressed to it and either takes in a two-byte word address followed by data, or streams bytes out of its storage for as long as the master keeps acknowledging.

A register array of `2**ADDR_BITS` bytes stands in for the nonvolatile array. One internal address counter serves both reads and writes, so a random read is a write of the word address, then a repeated start with the direction bit set. With `PAGE_SEL` set, the lowest chip-select position of the slave address no longer selects the device. It becomes a page bit that forms the top memory address bit, and the counter carries into it.

The data pin is open-drain. The block only ever pulls it low through `sdaPullLow`, and the pad or the bench forms the wired-AND.

Top module: `eeprom_twi_slave`

## Requirements
- R1: After reset `sdaPullLow` is 0 and the block ignores the bus until a start condition.
- R2: SDA falling while SCL is high is a start. From any state, including the middle of a byte, it restarts framing at bit 7 of a new slave-address byte.
- R3: SDA rising while SCL is high is a stop. It returns the block to idle with SDA released, and bytes clocked after it without a new start get no acknowledge.
- R4: With `PAGE_SEL`=0 the block pulls SDA low on the 9th clock of the slave-address byte only when bits 7..4 equal 1010 and bits 3..1 equal `selPins[2:0]`.
- R5: With `PAGE_SEL`=1 only bits 3..2 are compared, against `selPins[2:1]`, and `selPins[0]` is ignored. Bit 1 of the slave address is loaded into the top bit of the address counter.
- R6: After a slave address that does not match, SDA stays released for every later clock until the next start.
- R7: With direction bit 0 = write, the block acknowledges a high and then a low word-address byte and any number of data bytes. The counter loads the low `ADDR_BITS` bits of {high,low}, or the low `ADDR_BITS`-1 bits under the page bit when `PAGE_SEL`=1. Each data byte is stored at the counter, and the counter then steps by one.
- R8: With direction bit 1 = read, after the address acknowledge the block shifts out the byte at the counter, MSB first, and the counter then steps by one.
- R9: During a read, a low SDA on the 9th clock makes the block send the next byte. A high SDA makes it release SDA and stay silent until a stop or start.
- R10: The address counter wraps from `2**ADDR_BITS`-1 to 0. With `PAGE_SEL`=1 the page bit takes part in the carry.
- R11: `sdaPullLow` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad (wired-AND level) |
| selPins | input | 3 | Chip-select straps A2..A0 |
| sdaPullLow | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
The bench builds two copies with `ADDR_BITS`=6 on one shared bus: one with `PAGE_SEL`=0 strapped to select 101, and one with `PAGE_SEL`=1 strapped to 010. Because the memory is only 64 bytes, the whole array can be filled and read back in one burst, and the wrap from 63 to 0 can be reached directly, including the carry into the page bit. With the small address byte, every one of the 128 write-direction slave addresses is swept, and the expected acknowledge of both copies is computed from the code and select fields.

// File: rtl/twi_pkg.sv
package twi_pkg;
  localparam int BYTE_BITS = 8;
  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_RXACK, ST_TX, ST_TXACK, ST_WAIT
  } busState_t;

  typedef enum logic [1:0] {
    BK_DEV, BK_WHI, BK_WLO, BK_DATA
  } byteKind_t;

  typedef struct packed {
    logic shiftIn;
    logic bitVal;
    logic latchDev;
    logic loadHi;
    logic loadLo;
    logic writeMem;
    logic loadTx;
    logic shiftTx;
  } dpStrobe_t;
endpackage

// File: rtl/twi_sync.sv
module twi_sync #(
  parameter int WIDTH = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : gStage
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain[g] <= '1;
        else       chain[g] <= d;
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain[g] <= '1;
        else       chain[g] <= chain[g-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/twi_ctrl.sv
module twi_ctrl
  import twi_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclIn,
  input  logic      sdaIn,
  input  logic      devMatch,
  input  logic      rwRead,
  input  logic      memMsb,
  input  logic      txNext,
  output dpStrobe_t stb,
  output logic      sdaPullLow,
  output logic      sclLevel,
  output logic      startSeen,
  output logic      stopSeen,
  output logic      busIdle
);
  localparam int CNT_W = $clog2(BYTE_BITS);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_BITS - 1);

  logic [1:0] pinS;
  logic sclS, sdaS, sclD, sdaD, sclRise, sclFall;

  twi_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .d({sclIn, sdaIn}), .q(pinS)
  );
  assign sclS = pinS[1];
  assign sdaS = pinS[0];

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      sclD <= 1'b1;
      sdaD <= 1'b1;
    end else begin
      sclD <= sclS;
      sdaD <= sdaS;
    end

  assign startSeen = sclS & sclD & sdaD & ~sdaS;
  assign stopSeen  = sclS & sclD & ~sdaD & sdaS;
  assign sclRise   = sclS & ~sclD;
  assign sclFall   = ~sclS & sclD;
  assign sclLevel  = sclS;

  busState_t st, stN;
  byteKind_t kind, kindN;
  logic [CNT_W-1:0] bitCnt, cntN;
  logic byteDone, doneN, ackSeen, ackN, pullN;

  always_comb begin
    stb = '0;
    stb.bitVal = sdaS;
    stN = st;
    kindN = kind;
    cntN = bitCnt;
    doneN = byteDone;
    ackN = ackSeen;
    pullN = sdaPullLow;
    if (stopSeen) begin
      stN = ST_IDLE;
      pullN = 1'b0;
    end else if (startSeen) begin
      stN = ST_RX;
      kindN = BK_DEV;
      cntN = '0;
      doneN = 1'b0;
      pullN = 1'b0;
    end else begin
      case (st)
        ST_RX: begin
          if (sclRise) begin
            stb.shiftIn = 1'b1;
            cntN = bitCnt + 1'b1;
            if (bitCnt == LAST_BIT) doneN = 1'b1;
          end else if (sclFall && byteDone) begin
            doneN = 1'b0;
            cntN = '0;
            pullN = 1'b1;
            stN = ST_RXACK;
            case (kind)
              BK_DEV: begin
                if (devMatch) stb.latchDev = 1'b1;
                else begin
                  stN = ST_IDLE;
                  pullN = 1'b0;
                end
              end
              BK_WHI:  stb.loadHi = 1'b1;
              BK_WLO:  stb.loadLo = 1'b1;
              default: stb.writeMem = 1'b1;
            endcase
          end
        end
        ST_RXACK: begin
          if (sclFall) begin
            pullN = 1'b0;
            stN = ST_RX;
            cntN = '0;
            case (kind)
              BK_DEV: begin
                if (rwRead) begin
                  stN = ST_TX;
                  stb.loadTx = 1'b1;
                  pullN = ~memMsb;
                end else begin
                  kindN = BK_WHI;
                end
              end
              BK_WHI:  kindN = BK_WLO;
              default: kindN = BK_DATA;
            endcase
          end
        end
        ST_TX: begin
          if (sclFall) begin
            if (bitCnt == LAST_BIT) begin
              pullN = 1'b0;
              cntN = '0;
              stN = ST_TXACK;
            end else begin
              cntN = bitCnt + 1'b1;
              stb.shiftTx = 1'b1;
              pullN = ~txNext;
            end
          end
        end
        ST_TXACK: begin
          if (sclRise) ackN = ~sdaS;
          else if (sclFall) begin
            if (ackSeen) begin
              stb.loadTx = 1'b1;
              pullN = ~memMsb;
              cntN = '0;
              stN = ST_TX;
            end else begin
              stN = ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      st <= ST_IDLE;
      kind <= BK_DEV;
      bitCnt <= '0;
      byteDone <= 1'b0;
      ackSeen <= 1'b0;
      sdaPullLow <= 1'b0;
    end else begin
      st <= stN;
      kind <= kindN;
      bitCnt <= cntN;
      byteDone <= doneN;
      ackSeen <= ackN;
      sdaPullLow <= pullN;
    end

  assign busIdle = (st == ST_IDLE);
endmodule

// File: rtl/twi_datapath.sv
module twi_datapath
  import twi_pkg::*;
#(
  parameter int ADDR_BITS = 6,
  parameter bit PAGE_SEL = 1'b0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStrobe_t            stb,
  input  logic [2:0]           selPins,
  output logic                 devMatch,
  output logic                 rwRead,
  output logic                 memMsb,
  output logic                 txNext,
  output logic [ADDR_BITS-1:0] addrCnt
);
  localparam int DEPTH = 1 << ADDR_BITS;
  localparam int WORD_W = 2 * BYTE_BITS;

  logic [BYTE_BITS-1:0] rxShift, hiByte;
  logic [BYTE_BITS-2:0] txShift;
  logic [BYTE_BITS-1:0] mem [DEPTH];
  logic [BYTE_BITS-1:0] memByte;
  logic [WORD_W-1:0] wordAddr;
  logic [ADDR_BITS-1:0] loadAddr;

  assign wordAddr = {hiByte, rxShift};
  assign memByte = mem[addrCnt];
  assign memMsb = memByte[BYTE_BITS-1];
  assign txNext = txShift[BYTE_BITS-2];

  if (PAGE_SEL) begin : gPage
    assign devMatch = (rxShift[7:4] == DEV_CODE) && (rxShift[3:2] == selPins[2:1]);
    assign loadAddr = {addrCnt[ADDR_BITS-1], wordAddr[ADDR_BITS-2:0]};
    logic unusedBits;
    assign unusedBits = &{1'b0, selPins[0], wordAddr[WORD_W-1:ADDR_BITS-1]};
  end else begin : gFlat
    assign devMatch = (rxShift[7:4] == DEV_CODE) && (rxShift[3:1] == selPins);
    assign loadAddr = wordAddr[ADDR_BITS-1:0];
    logic unusedBits;
    assign unusedBits = &{1'b0, wordAddr[WORD_W-1:ADDR_BITS]};
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      rxShift <= '0;
      hiByte <= '0;
      txShift <= '0;
      rwRead <= 1'b0;
      addrCnt <= '0;
    end else begin
      if (stb.shiftIn) rxShift <= {rxShift[BYTE_BITS-2:0], stb.bitVal};
      if (stb.loadHi) hiByte <= rxShift;
      if (stb.latchDev) begin
        rwRead <= rxShift[0];
        if (PAGE_SEL) addrCnt[ADDR_BITS-1] <= rxShift[1];
      end
      if (stb.loadLo) addrCnt <= loadAddr;
      if (stb.writeMem || stb.loadTx) addrCnt <= addrCnt + 1'b1;
      if (stb.loadTx) txShift <= memByte[BYTE_BITS-2:0];
      else if (stb.shiftTx) txShift <= {txShift[BYTE_BITS-3:0], 1'b0};
    end

  always_ff @(posedge clk)
    if (stb.writeMem) mem[addrCnt] <= rxShift;
endmodule

// File: rtl/eeprom_twi_slave.sv
module eeprom_twi_slave
  import twi_pkg::*;
#(
  parameter int ADDR_BITS = 6,
  parameter bit PAGE_SEL = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] selPins,
  output logic       sdaPullLow
);
  dpStrobe_t stb;
  logic devMatch, rwRead, memMsb, txNext;
  logic sclLevel, startSeen, stopSeen, busIdle;
  logic [ADDR_BITS-1:0] addrCnt;

  twi_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .devMatch(devMatch), .rwRead(rwRead), .memMsb(memMsb), .txNext(txNext),
    .stb(stb), .sdaPullLow(sdaPullLow), .sclLevel(sclLevel),
    .startSeen(startSeen), .stopSeen(stopSeen), .busIdle(busIdle)
  );

  twi_datapath #(.ADDR_BITS(ADDR_BITS), .PAGE_SEL(PAGE_SEL)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .selPins(selPins),
    .devMatch(devMatch), .rwRead(rwRead), .memMsb(memMsb), .txNext(txNext),
    .addrCnt(addrCnt)
  );
endmodule

// File: rtl/eeprom_twi_slave_chk.sv
module eeprom_twi_slave_chk #(
  parameter int ADDR_BITS = 6
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 sclLevel,
  input logic                 startSeen,
  input logic                 stopSeen,
  input logic                 busIdle,
  input logic                 sdaPullLow,
  input logic                 writeStb,
  input logic                 loadTxStb,
  input logic [ADDR_BITS-1:0] addrCnt
);
  AST_PULL_WHILE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPullLow) |-> !sclLevel);  // R11
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> (!sdaPullLow && busIdle));  // R3
  AST_START_REFRAMES: assert property (@(posedge clk) disable iff (!rstN)
    startSeen |=> (!sdaPullLow && !busIdle));  // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    busIdle |-> !sdaPullLow);  // R6
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (writeStb || loadTxStb) |=> (addrCnt == ADDR_BITS'($past(addrCnt) + 1'b1)));  // R10
endmodule

bind eeprom_twi_slave eeprom_twi_slave_chk #(.ADDR_BITS(ADDR_BITS)) u_chk (
  .clk(clk), .rstN(rstN), .sclLevel(sclLevel), .startSeen(startSeen),
  .stopSeen(stopSeen), .busIdle(busIdle), .sdaPullLow(sdaPullLow),
  .writeStb(stb.writeMem), .loadTxStb(stb.loadTx), .addrCnt(addrCnt)
);

// File: tb/test_eeprom_twi_slave.sv
module test_eeprom_twi_slave;
  localparam int Q = 6;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic pullFlat, pullPage, line;
  int nChecks = 0;
  int nFails = 0;
  int highChanges = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  assign line = sdaM & ~pullFlat & ~pullPage;

  eeprom_twi_slave #(.ADDR_BITS(AW), .PAGE_SEL(1'b0)) i_eeprom_twi_slave (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(line),
    .selPins(3'b101), .sdaPullLow(pullFlat)
  );
  eeprom_twi_slave #(.ADDR_BITS(AW), .PAGE_SEL(1'b1)) i_eeprom_twi_slave_page (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(line),
    .selPins(3'b010), .sdaPullLow(pullPage)
  );

  // R11 monitor: a pull change while SCL stays high
  logic prevScl = 1'b1;
  logic [1:0] prevPull = 2'b00;
  always @(negedge clk) begin
    if (rstN && sclM && prevScl && ({pullFlat, pullPage} != prevPull)) highChanges++;
    prevScl = sclM;
    prevPull = {pullFlat, pullPage};
  end

  function automatic logic [7:0] patFlat(int i);
    return 8'((i * 13 + 5) & 255);
  endfunction
  function automatic logic [7:0] patPage(int i);
    return 8'((i * 29) & 255) ^ 8'h5C;
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic busStart();
    sdaM = 1'b1; tick(Q);
    sclM = 1'b1; tick(Q);
    sdaM = 1'b0; tick(Q);
    sclM = 1'b0; tick(Q);
  endtask

  task automatic busStop();
    sdaM = 1'b0; tick(Q);
    sclM = 1'b1; tick(Q);
    sdaM = 1'b1; tick(Q);
  endtask

  task automatic clockBit(output logic seen);
    tick(Q);
    sclM = 1'b1; tick(Q);
    seen = line; tick(Q);
    sclM = 1'b0; tick(1);
  endtask

  task automatic writeByte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i];
      clockBit(s);
    end
    sdaM = 1'b1;
    clockBit(s);
    acked = !s;
  endtask

  task automatic readByte(input logic giveAck, output logic [7:0] b);
    logic s;
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      clockBit(s);
      b[i] = s;
    end
    sdaM = !giveAck;
    clockBit(s);
    sdaM = 1'b1;
  endtask

  // Sets the counter with a write header; leaves the bus open for data or a restart
  task automatic setAddr(input logic [7:0] dev, input logic [7:0] hi, input logic [7:0] lo, string req);
    logic a;
    busStart();
    writeByte(dev, a); chk(a, req, a, 1);
    writeByte(hi, a);  chk(a, req, a, 1);
    writeByte(lo, a);  chk(a, req, a, 1);
  endtask

  task automatic readExpect(input logic [7:0] dev, input int n, input int startIdx, input bit page, string req);
    logic a;
    logic [7:0] d;
    int idx;
    busStart();
    writeByte(dev, a); chk(a, req, a, 1);
    for (int i = 0; i < n; i++) begin
      readByte(i != n - 1, d);
      idx = (startIdx + i) % DEPTH;
      if (page) chk(d == patPage(idx), req, d, patPage(idx));
      else chk(d == patFlat(idx), req, d, patFlat(idx));
    end
    busStop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] d;
    logic [7:0] addrByte;
    bit expAck;
    int allOk;

    tick(5);
    rstN = 1'b1;
    tick(5);
    // R1: released after reset
    chk(!pullFlat && !pullPage && line, "R1", {pullFlat, pullPage}, 0);

    // R4 R5: sweep every write-direction slave address
    for (int v = 0; v < 128; v++) begin
      addrByte = 8'(v << 1);
      expAck = ((v >> 3) == 10 && (v & 7) == 5) || ((v >> 3) == 10 && ((v >> 1) & 3) == 1);
      busStart();
      writeByte(addrByte, a);
      chk(a == expAck, "R4/R5 sweep", a, expAck);
      busStop();
    end

    // R7: fill flat copy from word 0
    setAddr(8'hAA, 8'h00, 8'h00, "R7");
    allOk = 1;
    for (int i = 0; i < DEPTH; i++) begin
      writeByte(patFlat(i), a);
      if (!a) allOk = 0;
    end
    chk(allOk == 1, "R7 data acks", allOk, 1);
    busStop();

    // R8 R9: random read of the whole array
    setAddr(8'hAA, 8'h00, 8'h00, "R8");
    readExpect(8'hAB, DEPTH, 0, 1'b0, "R8/R9 sequential");

    // R10: wrap on read; high byte bits above the array ignored (R7)
    setAddr(8'hAA, 8'h5A, 8'hFE, "R10");
    readExpect(8'hAB, 4, 62, 1'b0, "R10 read wrap");

    // R10: wrap on write
    setAddr(8'hAA, 8'h00, 8'h3F, "R10");
    writeByte(8'h11, a); chk(a, "R10", a, 1);
    writeByte(8'h22, a); chk(a, "R10", a, 1);
    busStop();
    setAddr(8'hAA, 8'h00, 8'h3F, "R10");
    busStart();
    writeByte(8'hAB, a);
    readByte(1'b1, d); chk(d == 8'h11, "R10 write wrap", d, 8'h11);
    readByte(1'b0, d); chk(d == 8'h22, "R10 write wrap", d, 8'h22);
    busStop();

    // R9: NACK ends the read; line stays released
    setAddr(8'hAA, 8'h00, 8'h05, "R9");
    busStart();
    writeByte(8'hAB, a);
    readByte(1'b0, d); chk(d == patFlat(5), "R9", d, patFlat(5));
    readByte(1'b0, d); chk(d == 8'hFF, "R9 after NACK", d, 8'hFF);
    busStop();

    // R6: nonmatching address, later bytes ignored
    busStart();
    writeByte(8'hA0, a); chk(!a, "R6", a, 0);
    writeByte(8'hAA, a); chk(!a, "R6", a, 0);
    writeByte(8'hA4, a); chk(!a, "R6", a, 0);
    busStop();

    // R3: stop mid-command, then a byte without start
    busStart();
    writeByte(8'hAA, a); chk(a, "R3", a, 1);
    writeByte(8'h00, a); chk(a, "R3", a, 1);
    busStop();
    writeByte(8'hAA, a); chk(!a, "R3 no start", a, 0);
    busStop();

    // R2: start in the middle of a byte
    busStart();
    sdaM = 1'b1; clockBit(a);
    sdaM = 1'b0; clockBit(a);
    sdaM = 1'b1; clockBit(a);
    setAddr(8'hAA, 8'h00, 8'h0A, "R2 restart");
    writeByte(8'h77, a); chk(a, "R2", a, 1);
    busStop();
    setAddr(8'hAA, 8'h00, 8'h0A, "R2");
    busStart();
    writeByte(8'hAB, a);
    readByte(1'b0, d); chk(d == 8'h77, "R2 data", d, 8'h77);
    busStop();

    // R5 R10: fill page copy from page 0 word 0; carry enters the page bit
    setAddr(8'hA4, 8'h00, 8'h00, "R5");
    allOk = 1;
    for (int i = 0; i < DEPTH; i++) begin
      writeByte(patPage(i), a);
      if (!a) allOk = 0;
    end
    chk(allOk == 1, "R5 data acks", allOk, 1);
    busStop();

    // R5: page bit 1, word 3 -> location 35
    setAddr(8'hA6, 8'h00, 8'h03, "R5");
    readExpect(8'hA7, 2, 35, 1'b1, "R5 page one");
    // R5: page bit 0; word bit 5 ignored -> location 3
    setAddr(8'hA4, 8'h00, 8'h23, "R5");
    readExpect(8'hA5, 2, 3, 1'b1, "R5 page zero");
    // R10: page copy wraps from 63 to 0
    setAddr(8'hA6, 8'h00, 8'h1F, "R10");
    readExpect(8'hA7, 2, 63, 1'b1, "R10 page wrap");

    // R11: no pull change seen while SCL was high
    chk(highChanges == 0, "R11", highChanges, 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule